// File: doc/BRIEF.md
# Chainable Stereo Gain Serial Port

This block is the control front end of a two-channel volume stage. A host writes a 16-bit control word over a three-wire serial link made of an active-low select, a serial clock and a data line. The word carries one 8-bit gain code for each channel, and each code is a plain unsigned number sent most significant bit first. When select goes high again, the last 16 bits received become the pending gain codes, and the block pulses a one-cycle update strobe that tells the gain stage to pick them up. A code of zero means the channel is muted, and the block reports that on a separate flag for each channel.

The serial pins are not treated as clocks. They pass through two-flop synchronizers into a fast system clock domain, and their edges are found there. This makes it possible to run the serial clock and data much slower than the system clock. Each bit that falls off the far end of the shift register is sent on a serial output that changes after serial-clock falling edges. Several ports can therefore share select and serial clock, with each output feeding the next port's data input. The whole chain then acts as a single shift register 16 bits long per port. The output enable follows select, so the output line floats while the port is not selected.

Top module: `gain_serial_port`

## Requirements
- R1: While reset is held, and after it is released until the first frame, both gain codes are 0x00, both mute flags are 1, the update strobe is 0, the serial output data is 0 and the output enable is 0 while select is high.
- R2: In a frame of exactly 16 serial-clock rising edges, the first 8 bits received become the right-channel code and the next 8 bits become the left-channel code. Each byte is sent most significant bit first.
- R3: The gain outputs keep their old values for the whole time select is low. They change only in the cycle after select rises.
- R4: Each rising edge of select produces exactly one update pulse, and that pulse is one system cycle wide.
- R5: While select is high, serial-clock edges and data changes do not alter the shift register. A later frame proves this, because its latched codes carry the older contents.
- R6: The shift register is not cleared when a frame starts. A frame of fewer than 16 bits latches the register as it stands: the oldest of the last 16 bits received goes to the right code, bit 7 first.
- R7: The serial output enable is 1 while select is low and 0 while select is high.
- R8: The serial output presents the bit shifted out of the far end of the register and changes only after a serial-clock falling edge. When two ports are chained in a 32-bit frame, the first 16 bits land in the far port and the last 16 bits land in the near port.
- R9: A mute flag is 1 exactly when the matching latched gain code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out to the next port in the chain |
| sdo_oe_o | output | 1 | Output enable for sdo_o; when it is 0, the pad is high impedance |
| gain_right_o | output | 8 | Pending right-channel gain code |
| gain_left_o | output | 8 | Pending left-channel gain code |
| mute_right_o | output | 1 | Right-channel code is zero |
| mute_left_o | output | 1 | Left-channel code is zero |
| update_o | output | 1 | One-cycle strobe when new codes are latched |

## Verification
A wrong bit in the shift register stays hidden until select rises. It then shows up as a wrong latched code within about four system cycles. In a chained setup it appears sooner, on the serial output, once the bad bit reaches the far end, which takes up to 16 serial clocks. A broken edge detector shows as a code that is shifted by one bit position or duplicated. A broken select detector shows as a missing or doubled update strobe, or as codes that change in the middle of a frame. The short-frame test and the test with select held high reveal a register that is cleared or shifted when it should not be, because the retained bits then appear in the right-channel code.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  // width of one channel gain code
  localparam int unsigned GSP_CODE_W   = 8;
  // number of channels carried in one control word
  localparam int unsigned GSP_CHANNELS = 2;
  // flops in each pin synchronizer
  localparam int unsigned GSP_SYNC_N   = 2;
  // pin index inside the synchronizer bus
  localparam int unsigned GSP_PIN_SEL  = 0;
  localparam int unsigned GSP_PIN_SCLK = 1;
  localparam int unsigned GSP_PIN_SDI  = 2;
  localparam int unsigned GSP_PINS     = 3;
endpackage

// File: rtl/gsp_rst_sync.sv
module gsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_s
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = pin_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign pin_s = stage_q[STAGES-1];
endmodule

// File: rtl/gsp_shifter.sv
module gsp_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_s,
  input  logic               sclk_s,
  input  logic               sdi_s,
  output logic [FRAME_W-1:0] word_o,
  output logic               sel_rise_o,
  output logic               sclk_fall_o,
  output logic               sdo_o
);
  logic               sclk_q, sclk_d;
  logic               sel_q, sel_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               sdo_q, sdo_d;
  logic               sclk_rise, sclk_fall, active;
  logic               shift_en, out_en;

  // next-state logic
  always_comb begin
    sclk_d    = sclk_s;
    sel_d     = sel_s;
    sclk_rise = sclk_s & ~sclk_q;
    sclk_fall = ~sclk_s & sclk_q;
    active    = ~sel_s;
    shift_en  = active & sclk_rise;
    out_en    = active & sclk_fall;
    shreg_d   = shreg_q;
    sdo_d     = sdo_q;
    if (shift_en) shreg_d = {shreg_q[FRAME_W-2:0], sdi_s};
    if (out_en)   sdo_d   = shreg_q[FRAME_W-1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sel_q   <= 1'b1;
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk_d;
      sel_q   <= sel_d;
      shreg_q <= shreg_d;
      sdo_q   <= sdo_d;
    end
  end

  assign word_o      = shreg_q;
  assign sel_rise_o  = sel_s & ~sel_q;
  assign sclk_fall_o = out_en;
  assign sdo_o       = sdo_q;
endmodule

// File: rtl/gsp_gain_bank.sv
module gsp_gain_bank #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned CHANNELS = 2,
  localparam int unsigned FRAME_W = CODE_W * CHANNELS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_i,
  input  logic [FRAME_W-1:0]                word_i,
  output logic [CHANNELS-1:0][CODE_W-1:0]   code_o,
  output logic [CHANNELS-1:0]               mute_o,
  output logic                              update_o
);
  logic upd_q, upd_d;

  // channel 0 is the byte shifted in first, so it sits at the top
  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      localparam int unsigned HI = FRAME_W - 1 - c * CODE_W;
      logic [CODE_W-1:0] code_q, code_d;
      logic              mute_q, mute_d;

      always_comb begin
        code_d = code_q;
        mute_d = mute_q;
        if (load_i) begin
          code_d = word_i[HI -: CODE_W];
          mute_d = (word_i[HI -: CODE_W] == '0);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= '0;
          mute_q <= 1'b1;
        end else begin
          code_q <= code_d;
          mute_q <= mute_d;
        end
      end

      assign code_o[c] = code_q;
      assign mute_o[c] = mute_q;
    end
  endgenerate

  always_comb upd_d = load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end

  assign update_o = upd_q;
endmodule

// File: rtl/gain_serial_port.sv
module gain_serial_port
  import gsp_pkg::*;
#(
  parameter int unsigned CODE_W = GSP_CODE_W,
  parameter int unsigned SYNC_N = GSP_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [CODE_W-1:0] gain_right_o,
  output logic [CODE_W-1:0] gain_left_o,
  output logic              mute_right_o,
  output logic              mute_left_o,
  output logic              update_o
);
  localparam int unsigned CHANNELS = GSP_CHANNELS;
  localparam int unsigned FRAME_W  = CODE_W * CHANNELS;
  localparam logic [GSP_PINS-1:0] PIN_RST = (GSP_PINS)'(1) << GSP_PIN_SEL;

  logic                            rst_int_n;
  logic [GSP_PINS-1:0]             pin_raw, pin_s;
  logic [FRAME_W-1:0]              word;
  logic                            sel_rise;
  logic                            sclk_fall_w;
  logic [CHANNELS-1:0][CODE_W-1:0] codes;
  logic [CHANNELS-1:0]             mutes;

  gsp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    pin_raw               = '0;
    pin_raw[GSP_PIN_SEL]  = sel_n_i;
    pin_raw[GSP_PIN_SCLK] = sclk_i;
    pin_raw[GSP_PIN_SDI]  = sdi_i;
  end

  gsp_sync #(.WIDTH(GSP_PINS), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_i (pin_raw),
    .pin_s (pin_s)
  );

  gsp_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sel_s       (pin_s[GSP_PIN_SEL]),
    .sclk_s      (pin_s[GSP_PIN_SCLK]),
    .sdi_s       (pin_s[GSP_PIN_SDI]),
    .word_o      (word),
    .sel_rise_o  (sel_rise),
    .sclk_fall_o (sclk_fall_w),
    .sdo_o       (sdo_o)
  );

  gsp_gain_bank #(.CODE_W(CODE_W), .CHANNELS(CHANNELS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (sel_rise),
    .word_i   (word),
    .code_o   (codes),
    .mute_o   (mutes),
    .update_o (update_o)
  );

  assign gain_right_o = codes[0];
  assign gain_left_o  = codes[1];
  assign mute_right_o = mutes[0];
  assign mute_left_o  = mutes[1];
  assign sdo_oe_o     = ~sel_n_i;
endmodule

// File: rtl/gsp_checker.sv
module gsp_checker #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              update_o,
  input logic [CODE_W-1:0] gain_right_o,
  input logic [CODE_W-1:0] gain_left_o,
  input logic              mute_right_o,
  input logic              mute_left_o,
  input logic              sdo_o,
  input logic              sclk_fall_w
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_codes_R1: assert (gain_right_o == '0 && gain_left_o == '0 && !update_o)
        else $error("reset codes not zero");
    end
  end

  assert_update_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  assert_gain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_right_o != $past(gain_right_o) || gain_left_o != $past(gain_left_o)) |-> update_o);

  assert_mute_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mute_right_o == (gain_right_o == '0));

  assert_mute_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mute_left_o == (gain_left_o == '0));

  assert_sdo_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(sclk_fall_w));
endmodule

bind gain_serial_port gsp_checker #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .update_o     (update_o),
  .gain_right_o (gain_right_o),
  .gain_left_o  (gain_left_o),
  .mute_right_o (mute_right_o),
  .mute_left_o  (mute_left_o),
  .sdo_o        (sdo_o),
  .sclk_fall_w  (sclk_fall_w)
);

// File: tb/gain_serial_port_bench.sv
module gain_serial_port_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe, upd, mr, ml;
  logic [7:0] gr, gl;
  logic sdo2, sdo_oe2, upd2, mr2, ml2, chain_d;
  logic [7:0] gr2, gl2;

  int checks = 0;
  int errors = 0;
  int upd_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gain_serial_port u_gain_serial_port (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .gain_right_o(gr), .gain_left_o(gl),
    .mute_right_o(mr), .mute_left_o(ml), .update_o(upd));

  assign chain_d = sdo_oe ? sdo : 1'b0;

  gain_serial_port u_far (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(chain_d),
    .sdo_o(sdo2), .sdo_oe_o(sdo_oe2), .gain_right_o(gr2), .gain_left_o(gl2),
    .mute_right_o(mr2), .mute_left_o(ml2), .update_o(upd2));

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    @(negedge clk);
    sel_n = 1'b0;
    wait_cyc(HALF);
    send_bits(v, n);
    wait_cyc(HALF);
    sel_n = 1'b1;
    wait_cyc(8);
  endtask

  task automatic t_reset;
    chk("R1 right", gr, 8'h00);
    chk("R1 left", gl, 8'h00);
    chk("R1 mutes", {mr, ml}, 2'b11);
    chk("R1 update", upd, 0);
    chk("R1 sdo", sdo, 0);
    chk("R7 oe idle", sdo_oe, 0);
  endtask

  task automatic t_basic;
    int c0 = upd_cnt;
    @(negedge clk);
    sel_n = 1'b0;
    wait_cyc(HALF);
    chk("R7 oe selected", sdo_oe, 1);
    send_bits(32'h5AC3, 16);
    wait_cyc(HALF);
    chk("R3 right held", gr, 8'h00);
    chk("R3 left held", gl, 8'h00);
    chk("R4 no early strobe", upd_cnt - c0, 0);
    sel_n = 1'b1;
    wait_cyc(8);
    chk("R2 right", gr, 8'h5A);
    chk("R2 left", gl, 8'hC3);
    chk("R9 mutes", {mr, ml}, 2'b00);
    chk("R4 one strobe", upd_cnt - c0, 1);
    chk("R7 oe released", sdo_oe, 0);
  endtask

  task automatic t_extremes;
    int c0 = upd_cnt;
    frame(32'hFF01, 16);
    chk("R2 right max", gr, 8'hFF);
    chk("R2 left min", gl, 8'h01);
    chk("R4 strobe", upd_cnt - c0, 1);
  endtask

  task automatic t_mute;
    frame(32'h0080, 16);
    chk("R9 right code", gr, 8'h00);
    chk("R9 right mute", mr, 1);
    chk("R9 left unmuted", ml, 0);
    chk("R2 left", gl, 8'h80);
  endtask

  task automatic t_short;
    int c0 = upd_cnt;
    frame(32'h3C, 8);
    chk("R6 right from old", gr, 8'h80);
    chk("R6 left new", gl, 8'h3C);
    chk("R6 strobe", upd_cnt - c0, 1);
  endtask

  task automatic t_ignored;
    int c0 = upd_cnt;
    sdi = 1'b1;
    for (int i = 0; i < 16; i++) begin
      wait_cyc(HALF); sclk = 1'b1; wait_cyc(HALF); sclk = 1'b0;
    end
    wait_cyc(8);
    chk("R5 right kept", gr, 8'h80);
    chk("R5 left kept", gl, 8'h3C);
    chk("R5 no strobe", upd_cnt - c0, 0);
    frame(32'h00, 8);
    chk("R5 register kept", gr, 8'h3C);
    chk("R9 left mute", ml, 1);
  endtask

  task automatic t_chain;
    frame(32'h9E47_2DB6, 32);
    chk("R8 near right", gr, 8'h2D);
    chk("R8 near left", gl, 8'hB6);
    chk("R8 far right", gr2, 8'h9E);
    chk("R8 far left", gl2, 8'h47);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait_cyc(4);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(6);
    t_reset();
    t_basic();
    t_extremes();
    t_mute();
    t_short();
    t_ignored();
    t_chain();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule